// File: doc/BRIEF.md
# Bit-manipulation micro-operation unit

This block holds a small register file of byte-wide entries and applies one micro-operation per clock to it. Each operation names a destination entry and, for the mask-driven operations, a source entry. The destination is both the operand and the place where the result goes. The source supplies a bit mask that selects which destination bits are forced high, inverted or forced low.

The other operations act on the destination alone. They rotate it left by one place, shift it right by one place keeping the sign, or shift it left by one place filling the bottom bit with zero. A caller presents an opcode with a valid strobe. One clock later the result is in the register file, and a done pulse comes out together with the new value. A separate combinational read port lets the caller inspect any entry at any time.

Top module: `bitop_unit`

## Requirements
- R1: After reset, entries 0, 1, 2 and 3 read 8'h00, 8'h9D, 8'hA5 and 8'h66 on the read port, and done is low.
- R2: Opcode 0 (mask set) writes dst | src into the destination entry.
- R3: Opcode 2 (mask complement) writes dst ^ src into the destination entry.
- R4: Opcode 4 (mask clear) writes dst & ~src into the destination entry.
- R5: Opcode 1 (rotate left) writes {dst[6:0], dst[7]} into the destination entry.
- R6: Opcode 3 (arithmetic shift right) writes {dst[7], dst[7:1]} into the destination entry.
- R7: Opcode 5 (logical shift left) writes {dst[6:0], 1'b0} into the destination entry.
- R8: A legal opcode with valid high at a clock edge updates only the destination entry at that edge. During the following cycle done is high and result carries the new value. Done is low in any cycle that does not follow such an edge.
- R9: Opcodes 6 and 7 write nothing and raise no done pulse.
- R10: The rotate and shift opcodes (1, 3, 5) ignore the source address.
- R11: When the source and destination addresses are equal, the mask is the entry's value before the write.
- R12: From reset, set(0,1), rotate(0), complement(0,2), arithmetic shift(0), clear(0,3) and logical shift(0) leave entry 0 at 8'h9D, 8'h3B, 8'h9E, 8'hCF, 8'h89 and 8'h12 in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Strobe: execute the presented operation at this edge |
| op_code | input | 3 | Operation code |
| dst_addr | input | 2 | Destination (first operand) entry |
| src_addr | input | 2 | Mask (second operand) entry |
| done | output | 1 | One-cycle pulse after a legal operation |
| result | output | 8 | New destination value, valid while done is high |
| rd_addr | input | 2 | Read port entry select |
| rd_data | output | 8 | Read port data (combinational) |

## Verification
The bench builds the unit with its default parameters: a byte-wide datapath, four entries and the reset image above. This setting makes the fixed six-step program reachable and lets every entry be read back after every operation. With only four entries, random address pairs often collide, so equal source and destination addresses come up often. Random opcodes cover all eight codes, including the two reserved ones, and a bench model predicts every entry after each operation.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   typedef enum logic [2:0] {
      OP_MSET = 3'd0,
      OP_ROL  = 3'd1,
      OP_MCPL = 3'd2,
      OP_ASR  = 3'd3,
      OP_MCLR = 3'd4,
      OP_LSL  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } bop_e;

   localparam int unsigned OP_W = 3;

   function automatic logic op_is_legal(input logic [OP_W-1:0] code);
      return (code <= 3'd5);
   endfunction

endpackage

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] y,
   output logic              legal
);

   localparam int unsigned MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("bitop_alu: DATA_W must be at least 2");
      end
   endgenerate

   always_comb begin
      legal = op_is_legal(op);
      unique case (op)
         OP_MSET: y = opnd | mask;
         OP_MCPL: y = opnd ^ mask;
         OP_MCLR: y = opnd & ~mask;
         OP_ROL:  y = {opnd[MSB-1:0], opnd[MSB]};
         OP_ASR:  y = {opnd[MSB], opnd[MSB:1]};
         OP_LSL:  y = {opnd[MSB-1:0], 1'b0};
         default: y = opnd;
      endcase
   end

endmodule

// File: rtl/bitop_rf.sv
module bitop_rf #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREGS  = 4,
   parameter logic [NREGS*DATA_W-1:0] RESET_IMAGE = '0,
   localparam int unsigned ADDR_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [ADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0] rb_data,
   input  logic [ADDR_W-1:0] rc_addr,
   output logic [DATA_W-1:0] rc_data
);

   logic [DATA_W-1:0] mem [NREGS];

   generate
      if ((1 << ADDR_W) != NREGS) begin : g_bad_depth
         $error("bitop_rf: NREGS must be a power of two");
      end
      for (genvar i = 0; i < NREGS; i++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[i] <= RESET_IMAGE[i*DATA_W +: DATA_W];
            else if (we && (waddr == ADDR_W'(i)))
               mem[i] <= wdata;
         end

         // R8: entries other than the addressed one keep their value
         a_r8_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (waddr == ADDR_W'(i))) |=> $stable(mem[i]));
      end
   endgenerate

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];
   assign rc_data = mem[rc_addr];

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREGS  = 4,
   parameter logic [NREGS*DATA_W-1:0] RESET_IMAGE = {8'h66, 8'hA5, 8'h9D, 8'h00},
   localparam int unsigned ADDR_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_code,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [ADDR_W-1:0] src_addr,
   output logic              done,
   output logic [DATA_W-1:0] result,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] dst_val;
   logic [DATA_W-1:0] src_val;
   logic [DATA_W-1:0] alu_y;
   logic              alu_legal;
   logic              wr_en;

   bitop_rf #(
      .DATA_W      (DATA_W),
      .NREGS       (NREGS),
      .RESET_IMAGE (RESET_IMAGE)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .waddr   (dst_addr),
      .wdata   (alu_y),
      .ra_addr (dst_addr),
      .ra_data (dst_val),
      .rb_addr (src_addr),
      .rb_data (src_val),
      .rc_addr (rd_addr),
      .rc_data (rd_data)
   );

   bitop_alu #(.DATA_W(DATA_W)) u_alu (
      .op    (op_code),
      .opnd  (dst_val),
      .mask  (src_val),
      .y     (alu_y),
      .legal (alu_legal)
   );

   assign wr_en = op_valid && alu_legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= wr_en;
         if (wr_en)
            result <= alu_y;
      end
   end

   // R8: a legal request is acknowledged on the next cycle
   a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && alu_legal) |=> done);
   // R8: no request, no pulse
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !done);
   // R9: reserved codes stay silent
   a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code[2] && op_code[1]) |=> !done);
   // R2: every mask bit ends up set
   a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_MSET) |=> ((result & $past(src_val)) == $past(src_val)));
   // R4: every mask bit ends up clear
   a_r4_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_MCLR) |=> ((result & $past(src_val)) == '0));
   // R5: old top bit wraps into bit 0
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_ROL) |=> (result[0] == $past(dst_val[DATA_W-1])));
   // R6: sign bit kept
   a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_ASR) |=> (result[DATA_W-1] == $past(dst_val[DATA_W-1])));
   // R7: zero fill at the bottom
   a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_LSL) |=> (result[0] == 1'b0));

endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [2:0] op_code = '0;
   logic [1:0] dst_addr = '0;
   logic [1:0] src_addr = '0;
   logic       done;
   logic [7:0] result;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   logic [7:0]  model [4];

   always #2 clk = ~clk;

   bitop_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .dst_addr(dst_addr), .src_addr(src_addr), .done(done), .result(result),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [7:0] expect_val(input logic [2:0] op,
                                             input logic [7:0] a,
                                             input logic [7:0] m);
      case (op)
         3'd0: return a | m;
         3'd1: return {a[6:0], a[7]};
         3'd2: return a ^ m;
         3'd3: return {a[7], a[7:1]};
         3'd4: return a & ~m;
         3'd5: return {a[6:0], 1'b0};
         default: return a;
      endcase
   endfunction

   function automatic string op_tag(input logic [2:0] op);
      case (op)
         3'd0: return "R2";
         3'd1: return "R5";
         3'd2: return "R3";
         3'd3: return "R6";
         3'd4: return "R4";
         3'd5: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all_entries(input string tag);
      for (int i = 0; i < 4; i++) begin
         rd_addr = 2'(i);
         #0.5;
         check(tag, rd_data, model[i]);
      end
   endtask

   // drive at a falling edge, inspect at the next falling edge
   task automatic do_op(input logic [2:0] op, input logic [1:0] d, input logic [1:0] s,
                        input string tag);
      logic [7:0] nv;
      logic       legal;
      nv = expect_val(op, model[d], model[s]);
      legal = (op <= 3'd5);
      op_valid = 1'b1; op_code = op; dst_addr = d; src_addr = s;
      @(negedge clk);
      op_valid = 1'b0;
      op_code = 3'($urandom);
      src_addr = 2'($urandom);
      if (legal) model[d] = nv;
      check({tag, " done"}, {7'd0, done}, {7'd0, legal});
      if (legal) check({tag, " result"}, result, nv);
      check_all_entries(tag);
      @(negedge clk);
      check("R8 done drop", {7'd0, done}, 8'd0);
   endtask

   initial begin
      model[0] = 8'h00; model[1] = 8'h9D; model[2] = 8'hA5; model[3] = 8'h66;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 done", {7'd0, done}, 8'd0);
      check_all_entries("R1");

      // R12 fixed program on entry 0
      do_op(3'd0, 2'd0, 2'd1, "R12 set");
      check("R12 step1", model[0], 8'h9D);
      do_op(3'd1, 2'd0, 2'd3, "R12 rol");
      check("R12 step2", model[0], 8'h3B);
      do_op(3'd2, 2'd0, 2'd2, "R12 cpl");
      check("R12 step3", model[0], 8'h9E);
      do_op(3'd3, 2'd0, 2'd1, "R12 asr");
      check("R12 step4", model[0], 8'hCF);
      do_op(3'd4, 2'd0, 2'd3, "R12 clr");
      check("R12 step5", model[0], 8'h89);
      do_op(3'd5, 2'd0, 2'd2, "R12 lsl");
      check("R12 step6", model[0], 8'h12);

      // R9 reserved codes leave everything alone
      do_op(3'd6, 2'd1, 2'd2, "R9 code6");
      do_op(3'd7, 2'd3, 2'd0, "R9 code7");

      // R10 single-operand ops with varied source addresses
      do_op(3'd1, 2'd2, 2'd2, "R10 rol");
      do_op(3'd3, 2'd2, 2'd0, "R10 asr");
      do_op(3'd5, 2'd3, 2'd1, "R10 lsl");

      // R11 source equals destination
      do_op(3'd0, 2'd1, 2'd1, "R11 set");
      do_op(3'd2, 2'd1, 2'd1, "R11 cpl");
      check("R11 cpl zero", model[1], 8'h00);
      do_op(3'd4, 2'd3, 2'd3, "R11 clr");
      check("R11 clr zero", model[3], 8'h00);

      // R8 back-to-back legal ops keep done high
      op_valid = 1'b1; op_code = 3'd0; dst_addr = 2'd2; src_addr = 2'd0;
      model[2] = model[2] | model[0];
      @(negedge clk);
      check("R8 b2b first", result, model[2]);
      op_code = 3'd1; dst_addr = 2'd2;
      model[2] = {model[2][6:0], model[2][7]};
      @(negedge clk);
      op_valid = 1'b0;
      check("R8 b2b done", {7'd0, done}, 8'd1);
      check("R8 b2b second", result, model[2]);
      @(negedge clk);

      // random mix over all codes
      for (int k = 0; k < 400; k++) begin
         logic [2:0] op;
         op = 3'($urandom);
         do_op(op, 2'($urandom), 2'($urandom), op_tag(op));
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #100000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule